// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two elements of GF(2^12), treating each element as a degree-one polynomial `hi*y + lo` over GF(2^6), where y satisfies `y^2 = y + 0x21`. Three GF(64) products are formed in Karatsuba fashion (the product of the half-sums, the product of the low halves, the product of the high halves); the high-half product is then scaled by the fixed GF(64) constant 0x21. These pieces combine into the two result halves. Every GF(64) product is shift-and-add over six steps, reduced by x^6 + x + 1.

A step mode turns the block into a generator walker. With the step flag set, the second operand is ignored and the first is multiplied by the fixed element 0xE01, and a zero input yields 1. Feeding each result back as the next input walks through the powers of the generator. A parameter picks a registered result (one cycle of latency, the default) or a purely combinational one.

Top module: `gf4096_tower_mult`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_prod` become 0.
- R2: With `REG_OUT=1`, `out_valid` is high in the cycle after an edge that samples `in_valid` high, and low in the cycle after an edge that samples it low.
- R3: Normal mode (`in_step=0`): each operand splits into hi = bits 11:6 and lo = bits 5:0. GF(64) multiplication reduces by x^6+x+1 (0x43). The result hi is (ah^al)*(bh^bl) ^ al*bl, the result lo is 0x21*(ah*bh) ^ al*bl, and `out_prod = {hi, lo}`.
- R4: In normal mode, a zero operand on either side gives a product of 0.
- R5: In normal mode, the operand 0x001 is the identity: the product equals the other operand.
- R6: The product is commutative: swapping `in_a` and `in_b` gives the same result.
- R7: Step mode (`in_step=1`) with nonzero `in_a` yields `in_a` times 0xE01 under the R3 rule; `in_b` has no effect on the result.
- R8: Step mode with `in_a = 0` yields 0x001.
- R9: With `REG_OUT=1`, `out_prod` keeps its value across any edge where `in_valid` is low.
- R10: Starting from 0x001 and applying step mode to each result in turn, the 4095th result is 0x001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| in_step | input | 1 | 1: generator step on `in_a`; 0: multiply `in_a` by `in_b` |
| in_a | input | 12 | First operand |
| in_b | input | 12 | Second operand (ignored in step mode) |
| out_valid | output | 1 | Product present |
| out_prod | output | 12 | GF(4096) product |

## Verification
The bench builds the block with its defaults: `REG_OUT=1`, the 0x43 reduction polynomial, extension constant 0x21 and generator 0xE01. The registered build makes the one-cycle latency and hold behaviour observable. Feeding results back makes the full 4095-step generator orbit reachable within a few thousand cycles. The field constants let a reference model be built in the bench that uses a different GF(64) algorithm: a full carry-less product followed by top-down reduction.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

    localparam int HALF_W = 6;
    localparam int FULL_W = 2 * HALF_W;

    // x^6 + x + 1, with the x^6 term dropped
    localparam logic [HALF_W-1:0] GF64_POLY_LOW = 6'h03;
    // y^2 = y + EXT_CONST
    localparam logic [HALF_W-1:0] EXT_CONST = 6'h21;
    localparam logic [FULL_W-1:0] GEN_CONST = 12'hE01;
    localparam logic [FULL_W-1:0] FIELD_ONE = 12'h001;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [FULL_W-1:0] full_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } tower_t;

    typedef enum logic {
        OP_MUL  = 1'b0,
        OP_STEP = 1'b1
    } op_e;

    // multiply by x with reduction
    function automatic half_t gf64_xtime(input half_t v);
        half_t r;
        r = {v[HALF_W-2:0], 1'b0};
        if (v[HALF_W-1])
            r = r ^ GF64_POLY_LOW;
        return r;
    endfunction

    // shift-and-add product over HALF_W steps
    function automatic half_t gf64_mul(input half_t x, input half_t y);
        half_t acc;
        half_t sh;
        acc = '0;
        sh  = y;
        for (int i = 0; i < HALF_W; i++) begin
            if (x[i])
                acc = acc ^ sh;
            sh = gf64_xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gf64_mult.sv
module gf64_mult
    import gf_tower_pkg::*;
(
    input  half_t x,
    input  half_t y,
    output half_t z
);
    assign z = gf64_mul(x, y);
endmodule

// File: rtl/gf_tower_core.sv
module gf_tower_core
    import gf_tower_pkg::*;
(
    input  tower_t a,
    input  tower_t b,
    output tower_t p
);
    half_t sum_a, sum_b;
    half_t p_mid, p_low, p_high, p_scaled;

    assign sum_a = a.hi ^ a.lo;
    assign sum_b = b.hi ^ b.lo;

    gf64_mult u_mid   (.x(sum_a),  .y(sum_b),     .z(p_mid));
    gf64_mult u_low   (.x(a.lo),   .y(b.lo),      .z(p_low));
    gf64_mult u_high  (.x(a.hi),   .y(b.hi),      .z(p_high));
    gf64_mult u_scale (.x(p_high), .y(EXT_CONST), .z(p_scaled));

    assign p.hi = p_mid ^ p_low;
    assign p.lo = p_scaled ^ p_low;
endmodule

// File: rtl/gf4096_tower_mult.sv
module gf4096_tower_mult
    import gf_tower_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_step,
    input  logic [FULL_W-1:0] in_a,
    input  logic [FULL_W-1:0] in_b,
    output logic              out_valid,
    output logic [FULL_W-1:0] out_prod
);
    op_e    op;
    tower_t opnd_a, opnd_b, core_p;
    full_t  result;
    logic   step_zero;

    assign op        = op_e'(in_step);
    assign opnd_a    = tower_t'(in_a);
    assign opnd_b    = (op == OP_STEP) ? tower_t'(GEN_CONST) : tower_t'(in_b);
    assign step_zero = (op == OP_STEP) && (in_a == '0);

    gf_tower_core u_core (.a(opnd_a), .b(opnd_b), .p(core_p));

    assign result = step_zero ? FIELD_ONE : full_t'(core_p);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_prod  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid)
                        out_prod <= result;
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_prod  = result;
        end
    endgenerate
endmodule

// File: rtl/gf_tower_chk.sv
module gf_tower_chk
    import gf_tower_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_step,
    input logic [FULL_W-1:0] in_a,
    input logic [FULL_W-1:0] in_b,
    input logic              out_valid,
    input logic [FULL_W-1:0] out_prod
);
    generate
        if (REG_OUT) begin : g_chk
            assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !in_step && (in_a == '0 || in_b == '0)) |=> (out_prod == '0));
            assert_one_R5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !in_step && in_b == FIELD_ONE) |=> (out_prod == $past(in_a)));
            assert_step_zero_R8: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_step && in_a == '0) |=> (out_prod == FIELD_ONE));
            assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(out_prod));
        end
    endgenerate
endmodule

bind gf4096_tower_mult gf_tower_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_step(in_step),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/tb_gf4096_tower_mult.sv
module tb_gf4096_tower_mult;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_step = 1'b0;
    logic [11:0] in_a = '0;
    logic [11:0] in_b = '0;
    logic        out_valid;
    logic [11:0] out_prod;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf4096_tower_mult dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_step(in_step),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
    );

    // reference: full carry-less product, then reduce from the top bit down
    function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
        logic [10:0] t;
        t = '0;
        for (int i = 0; i < 6; i++)
            if (y[i]) t = t ^ (11'(x) << i);
        for (int k = 10; k >= 6; k--)
            if (t[k]) t = t ^ (11'h43 << (k - 6));
        return t[5:0];
    endfunction

    // (ah y + al)(bh y + bl) with y^2 = y + 0x21
    function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hh, hl, lh, ll, hi, lo;
        hh = ref64(a[11:6], b[11:6]);
        hl = ref64(a[11:6], b[5:0]);
        lh = ref64(a[5:0], b[11:6]);
        ll = ref64(a[5:0], b[5:0]);
        hi = hh ^ hl ^ lh;
        lo = ref64(hh, 6'h21) ^ ll;
        return {hi, lo};
    endfunction

    function automatic logic [11:0] ref_step(input logic [11:0] a);
        return (a == '0) ? 12'h001 : ref_mul(a, 12'hE01);
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic next_rand(output logic [11:0] v);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = lfsr[11:0] ^ lfsr[15:4];
    endtask

    // drive one operation, return the registered result
    task automatic apply(input logic step, input logic [11:0] a, input logic [11:0] b,
                         output logic [11:0] r, output logic v);
        @(negedge clk);
        in_valid = 1'b1; in_step = step; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        r = out_prod; v = out_valid;
    endtask

    task automatic t_reset();
        check("R1 out_valid", {11'b0, out_valid}, 12'h000);
        check("R1 out_prod", out_prod, 12'h000);
    endtask

    task automatic t_valid();
        logic [11:0] r; logic v;
        apply(1'b0, 12'h123, 12'h456, r, v);
        check("R2 valid after one cycle", {11'b0, v}, 12'h001);
        check("R3 fixed pair", r, ref_mul(12'h123, 12'h456));
        @(negedge clk);
        check("R2 valid drops", {11'b0, out_valid}, 12'h000);
    endtask

    task automatic t_random();
        logic [11:0] a, b, r; logic v;
        for (int i = 0; i < 300; i++) begin
            next_rand(a); next_rand(b);
            apply(1'b0, a, b, r, v);
            check("R3 random", r, ref_mul(a, b));
        end
        apply(1'b0, 12'hFFF, 12'hFFF, r, v);
        check("R3 all ones", r, ref_mul(12'hFFF, 12'hFFF));
        apply(1'b0, 12'hFC0, 12'h03F, r, v);
        check("R3 hi times lo", r, ref_mul(12'hFC0, 12'h03F));
    endtask

    task automatic t_zero_one();
        logic [11:0] a, r; logic v;
        for (int i = 0; i < 20; i++) begin
            next_rand(a);
            apply(1'b0, a, 12'h000, r, v);
            check("R4 times zero", r, 12'h000);
            apply(1'b0, 12'h000, a, r, v);
            check("R4 zero times", r, 12'h000);
            apply(1'b0, a, 12'h001, r, v);
            check("R5 times one", r, a);
            apply(1'b0, 12'h001, a, r, v);
            check("R5 one times", r, a);
        end
    endtask

    task automatic t_commute();
        logic [11:0] a, b, r1, r2; logic v;
        for (int i = 0; i < 50; i++) begin
            next_rand(a); next_rand(b);
            apply(1'b0, a, b, r1, v);
            apply(1'b0, b, a, r2, v);
            check("R6 commutative", r2, r1);
        end
    endtask

    task automatic t_step();
        logic [11:0] a, b, r; logic v;
        for (int i = 0; i < 30; i++) begin
            next_rand(a); next_rand(b);
            if (a == '0) a = 12'h5A5;
            apply(1'b1, a, b, r, v);
            check("R7 step ignores b", r, ref_mul(a, 12'hE01));
        end
        apply(1'b1, 12'h000, 12'h777, r, v);
        check("R8 step of zero", r, 12'h001);
    endtask

    task automatic t_hold();
        logic [11:0] r; logic v;
        apply(1'b0, 12'hABC, 12'h321, r, v);
        @(negedge clk);
        in_valid = 1'b0; in_a = 12'h999; in_b = 12'h111;
        @(negedge clk);
        check("R9 hold", out_prod, ref_mul(12'hABC, 12'h321));
        in_step = 1'b1;
        @(negedge clk);
        in_step = 1'b0;
        check("R9 hold step", out_prod, ref_mul(12'hABC, 12'h321));
    endtask

    task automatic t_orbit();
        logic [11:0] cur, r; logic v;
        int bad = 0;
        cur = 12'h001;
        for (int i = 1; i <= 4095; i++) begin
            apply(1'b1, cur, 12'h000, r, v);
            if (r !== ref_step(cur)) bad++;
            cur = r;
        end
        check("R10 per-step mismatches", 12'(bad), 12'h000);
        check("R10 returns to one", cur, 12'h001);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_valid();
        t_random();
        t_zero_one();
        t_commute();
        t_step();
        t_hold();
        t_orbit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule